// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Controller

This block sits between a synchronous user port and an external 16-bit pseudo-static RAM run in its asynchronous mode. A user pulses a request with an operation kind (read, write or configuration-register write), a 23-bit word address, write data and two byte enables. The controller drives the memory's active-low strobes, holds them for a number of clock cycles computed from the device access times, samples or drives the data bus, and returns a one-cycle acknowledge with the read data.

After a read the controller keeps chip-enable low for a short hold window. A further read that arrives in this window and addresses the same 16-word page (address bits 22:4 unchanged) completes after the short page access count instead of the full random access count. A write or configuration write that arrives in the window first gets one cycle with every strobe inactive, so the device has released the bus before the controller drives it. When the window expires, chip-enable is released and the device drops into standby.

Top module: `psram_async_ctrl`

## Requirements
- R1: During and directly after reset every active-low strobe is high, `mem_cre` is 0, `mem_dq_oe` is 0, `ack` is 0 and `busy` is 0.
- R2: A random read holds `mem_ce_n`, `mem_adv_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` low with `mem_we_n` high, `mem_cre` 0 and `mem_dq_oe` 0 for exactly RD_CYC cycles (7 by default, the ceiling of 70 ns over the 10 ns design clock), with `mem_addr` equal to the request address.
- R3: A read accepted inside the hold window whose address bits 22:4 equal those of the previous read keeps the read strobes for exactly PG_CYC cycles (2 by default).
- R4: A read accepted inside the hold window with different address bits 22:4, or any read accepted after the window has expired, takes RD_CYC cycles.
- R5: A write holds `mem_ce_n`, `mem_adv_n` and `mem_we_n` low with `mem_oe_n` high and `mem_cre` 0 for exactly WR_CYC cycles (7 by default); during it `mem_dq_oe` is 1, `mem_dq_o` equals the write data, `mem_lb_n` is the inverse of byte enable bit 0 (data bits 7:0) and `mem_ub_n` the inverse of bit 1 (bits 15:8).
- R6: A configuration write holds `mem_cre` 1 with `mem_ce_n`, `mem_adv_n`, `mem_we_n` low, `mem_oe_n`, `mem_ub_n`, `mem_lb_n` high and `mem_dq_oe` 0 for WR_CYC cycles; the register value is on `mem_addr` with bit 15 forced to 1 so the device stays asynchronous.
- R7: A write or configuration write accepted inside the hold window is preceded by exactly one cycle with every strobe inactive; accepted from standby it starts in the cycle after acceptance.
- R8: After a read, `mem_ce_n` stays low with all other strobes high for HOLD_CYC cycles (4 by default) counted from the acknowledge cycle, then goes high.
- R9: A request presented while `busy` is 1 is ignored and starts no access.
- R10: `ack` is high for exactly one cycle, in the cycle after the last strobe cycle; `rd_data` then holds the bus value sampled in that last read cycle and keeps it until the next read completes.
- R11: `mem_dq_oe` is 1 only while `mem_we_n` is low for a memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pulse, taken when not busy |
| req_write | input | 1 | 1 = memory write, 0 = read |
| req_cfg | input | 1 | 1 = configuration write (overrides req_write) |
| req_addr | input | 23 | Word address, or register value for a configuration write |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| busy | output | 1 | An access is in progress |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data of the last completed read |
| mem_addr | output | 23 | Memory address lines |
| mem_dq_o | output | 16 | Data driven to the memory |
| mem_dq_oe | output | 1 | Enable for the data driver |
| mem_dq_i | input | 16 | Data from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_cre | output | 1 | Configuration register enable |

## Verification
Reads are issued with back-to-back addresses in the same page, in a different page, and after gaps of zero to five idle cycles, which separates the short page count from the full random count and pins down the exact edge of the hold window. Writes with every byte-enable pattern and configuration writes with bit 15 clear are mixed in, each directly after a read and from standby, so the turnaround cycle is seen present and absent. A request pulsed in the middle of an access shows whether busy requests leak into a second access, and the read data bus is a function of the address so a stale or mis-timed sample gives a wrong value.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [1:0] {K_READ, K_WRITE, K_CFG} kind_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WRITE, ST_CFG, ST_HOLD, ST_TURN
  } state_t;

  typedef struct packed {
    logic ce_n;
    logic adv_n;
    logic oe_n;
    logic we_n;
    logic ub_n;
    logic lb_n;
    logic cre;
  } strobe_t;

  localparam strobe_t STROBE_OFF  = '{ce_n: 1'b1, adv_n: 1'b1, oe_n: 1'b1,
                                      we_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1,
                                      cre: 1'b0};
  localparam strobe_t STROBE_HOLD = '{ce_n: 1'b0, adv_n: 1'b1, oe_n: 1'b1,
                                      we_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1,
                                      cre: 1'b0};

  // clock cycles needed to cover a delay, never less than one
  function automatic int cycles_for(int delay_ps, int clk_ps);
    int c;
    c = (delay_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic strobe_t access_strobes(kind_t k, logic [1:0] be);
    strobe_t s;
    s       = STROBE_OFF;
    s.ce_n  = 1'b0;
    s.adv_n = 1'b0;
    case (k)
      K_READ: begin
        s.oe_n = 1'b0;
        s.ub_n = 1'b0;
        s.lb_n = 1'b0;
      end
      K_WRITE: begin
        s.we_n = 1'b0;
        s.ub_n = ~be[1];
        s.lb_n = ~be[0];
      end
      default: begin
        s.we_n = 1'b0;
        s.cre  = 1'b1;
      end
    endcase
    return s;
  endfunction

  function automatic state_t kind_state(kind_t k);
    case (k)
      K_READ:  return ST_READ;
      K_WRITE: return ST_WRITE;
      default: return ST_CFG;
    endcase
  endfunction

endpackage

// File: rtl/psram_wait_timer.sv
module psram_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // R2: a running count only moves downwards by one
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/psram_page_tracker.sv
module psram_page_tracker #(
  parameter int TAG_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic             clear,
  input  logic [TAG_W-1:0] tag_in,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             hit
);

  logic             valid_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (capture) begin
      valid_q <= 1'b1;
      tag_q   <= tag_in;
    end else if (clear) begin
      valid_q <= 1'b0;
    end
  end

  assign hit = valid_q && (tag_q == probe_tag);

  // R4: after a clear no page hit is reported
  clear_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (clear && !capture) |=> !hit);

endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W       = 23,
  parameter int DATA_W       = 16,
  parameter int PAGE_LSB     = 4,
  parameter int CLK_PS       = 10000,
  parameter int T_RAND_PS    = 70000,
  parameter int T_PAGE_PS    = 20000,
  parameter int T_WRITE_PS   = 70000,
  parameter int HOLD_CYC     = 4,
  parameter int CFG_MODE_BIT = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_cfg,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              busy,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic              mem_adv_n,
  output logic              mem_cre
);

  localparam int RD_CYC  = cycles_for(T_RAND_PS, CLK_PS);
  localparam int PG_CYC  = cycles_for(T_PAGE_PS, CLK_PS);
  localparam int WR_CYC  = cycles_for(T_WRITE_PS, CLK_PS);
  localparam int MAX_A   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int MAX_CYC = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int TAG_W   = ADDR_W - PAGE_LSB;

  state_t            state_q;
  kind_t             kind_q;
  logic [1:0]        be_q;
  strobe_t           strb_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              dq_oe_q;
  logic              ack_q;

  kind_t             req_kind;
  logic              ready;
  logic              accept;
  logic              need_turn;
  logic              tag_hit;
  logic              page_hit;
  logic              t_done;
  logic              t_load;
  logic [CNT_W-1:0]  t_val;
  logic              hold_end;
  logic              finish_read;

  assign req_kind    = req_cfg ? K_CFG : (req_write ? K_WRITE : K_READ);
  assign ready       = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign accept      = req_valid && ready;
  assign need_turn   = accept && (state_q == ST_HOLD) && (req_kind != K_READ);
  assign page_hit    = tag_hit && (state_q == ST_HOLD);
  assign hold_end    = (state_q == ST_HOLD) && !accept && t_done;
  assign finish_read = (state_q == ST_READ) && t_done;

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (accept && !need_turn) begin
      t_load = 1'b1;
      if (req_kind == K_READ) begin
        t_val = page_hit ? CNT_W'(PG_CYC - 1) : CNT_W'(RD_CYC - 1);
      end else begin
        t_val = CNT_W'(WR_CYC - 1);
      end
    end else if (state_q == ST_TURN) begin
      t_load = 1'b1;
      t_val  = CNT_W'(WR_CYC - 1);
    end else if (finish_read) begin
      t_load = 1'b1;
      t_val  = CNT_W'(HOLD_CYC - 1);
    end
  end

  psram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  psram_page_tracker #(.TAG_W(TAG_W)) u_page (
    .clk       (clk),
    .rst       (rst),
    .capture   (accept && (req_kind == K_READ)),
    .clear     ((accept && (req_kind != K_READ)) || hold_end),
    .tag_in    (req_addr[ADDR_W-1:PAGE_LSB]),
    .probe_tag (req_addr[ADDR_W-1:PAGE_LSB]),
    .hit       (tag_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      kind_q  <= K_READ;
      be_q    <= '0;
      strb_q  <= STROBE_OFF;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      dq_oe_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      case (state_q)
        ST_IDLE, ST_HOLD: begin
          if (accept) begin
            kind_q  <= req_kind;
            be_q    <= req_be;
            wdata_q <= req_wdata;
            addr_q  <= (req_kind == K_CFG) ?
                       (req_addr | (ADDR_W'(1) << CFG_MODE_BIT)) : req_addr;
            if (need_turn) begin
              state_q <= ST_TURN;
              strb_q  <= STROBE_OFF;
            end else begin
              state_q <= kind_state(req_kind);
              strb_q  <= access_strobes(req_kind, req_be);
              dq_oe_q <= (req_kind == K_WRITE);
            end
          end else if (hold_end) begin
            state_q <= ST_IDLE;
            strb_q  <= STROBE_OFF;
          end
        end
        ST_TURN: begin
          state_q <= kind_state(kind_q);
          strb_q  <= access_strobes(kind_q, be_q);
          dq_oe_q <= (kind_q == K_WRITE);
        end
        ST_READ: begin
          if (t_done) begin
            rdata_q <= mem_dq_i;
            ack_q   <= 1'b1;
            state_q <= ST_HOLD;
            strb_q  <= STROBE_HOLD;
          end
        end
        default: begin
          if (t_done) begin
            ack_q   <= 1'b1;
            state_q <= ST_IDLE;
            strb_q  <= STROBE_OFF;
            dq_oe_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign busy      = !ready;
  assign ack       = ack_q;
  assign rd_data   = rdata_q;
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = dq_oe_q;
  assign mem_ce_n  = strb_q.ce_n;
  assign mem_oe_n  = strb_q.oe_n;
  assign mem_we_n  = strb_q.we_n;
  assign mem_ub_n  = strb_q.ub_n;
  assign mem_lb_n  = strb_q.lb_n;
  assign mem_adv_n = strb_q.adv_n;
  assign mem_cre   = strb_q.cre;

  // R2
  rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_cre && !mem_dq_oe));

  // R11
  dq_drive_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && !mem_cre && mem_oe_n));

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R7
  wr_after_standby_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> ($past(mem_ce_n) && $past(mem_oe_n)));

  // R6
  cfg_mode_chk: assert property (@(posedge clk) disable iff (rst)
    mem_cre |-> (mem_addr[CFG_MODE_BIT] && !mem_we_n && !mem_dq_oe));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !ack && $past(busy)) |-> $stable(mem_addr));

endmodule

// File: tb/test_psram_async_ctrl.sv
`timescale 1ns/1ps
module test_psram_async_ctrl;

  localparam int RD   = 7;
  localparam int PG   = 2;
  localparam int WR   = 7;
  localparam int HOLD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_cfg = 1'b0;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        busy, ack;
  logic [15:0] rd_data;
  logic [22:0] mem_addr;
  logic [15:0] mem_dq_o, mem_dq_i;
  logic        mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
  logic        mem_ub_n, mem_lb_n, mem_adv_n, mem_cre;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] pat(logic [22:0] a);
    return 16'hA5C3 ^ a[15:0] ^ {a[22:16], 9'd0};
  endfunction

  assign mem_dq_i = (!mem_ce_n && !mem_oe_n) ? pat(mem_addr) : 16'h0000;

  psram_async_ctrl i_psram_async_ctrl (
    .clk, .rst, .req_valid, .req_write, .req_cfg, .req_addr, .req_wdata,
    .req_be, .busy, .ack, .rd_data, .mem_addr, .mem_dq_o, .mem_dq_oe,
    .mem_dq_i, .mem_ce_n, .mem_oe_n, .mem_we_n, .mem_ub_n, .mem_lb_n,
    .mem_adv_n, .mem_cre
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench model of the hold window
  bit          prev_read = 0;
  logic [18:0] prev_page = '0;
  logic [15:0] last_rd   = '0;

  // kind: 0 read, 1 write, 2 cfg
  task automatic do_op(int kind, logic [22:0] addr, logic [15:0] wd,
                       logic [1:0] be, int delay, bit spurious);
    int  cnt = 0, gap = 0, guard = 0;
    bit  seen = 0, in_win, drop = 0, got_ack = 0;
    int  exp_cnt, exp_gap;
    logic [31:0] s_addr = '0, s_dq = '0;
    logic s_adv = 1, s_oe = 1, s_we = 1, s_ub = 1, s_lb = 1, s_cre = 0, s_oe_en = 0;
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      if (i == 0) chk(ack == 1'b0, "R10 ack width", ack, 0);
    end
    in_win = prev_read && (delay < HOLD);
    req_valid = 1; req_write = (kind == 1); req_cfg = (kind == 2);
    req_addr = addr; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 0;
    while (!got_ack && guard < 40) begin
      guard++;
      if (drop) begin req_valid = 0; drop = 0; end
      if (ack) got_ack = 1;
      else begin
        if ((kind == 0 && !mem_oe_n) || (kind != 0 && !mem_we_n)) begin
          cnt++; seen = 1;
          s_addr = 32'(mem_addr); s_dq = 32'(mem_dq_o); s_adv = mem_adv_n;
          s_oe = mem_oe_n; s_we = mem_we_n; s_ub = mem_ub_n; s_lb = mem_lb_n;
          s_cre = mem_cre; s_oe_en = mem_dq_oe;
        end else if (!seen && mem_ce_n) gap++;
        if (spurious && cnt == 2 && !drop) begin
          req_valid = 1; req_write = 1; req_cfg = 0; drop = 1;
        end
        @(negedge clk);
      end
    end
    req_valid = 0;
    chk(got_ack, "R10 ack seen", 32'(got_ack), 1);
    if (kind == 0) begin
      exp_cnt = (in_win && addr[22:4] == prev_page) ? PG : RD;
      chk(cnt == exp_cnt, (exp_cnt == PG) ? "R3 page read length" : "R4 random read length",
          cnt, exp_cnt);
      chk(s_addr == 32'(addr) && !s_adv && s_we && !s_ub && !s_lb && !s_cre && !s_oe_en,
          "R2 read strobes", {s_adv, s_we, s_ub, s_lb, s_cre, s_oe_en}, 6'b010000);
      chk(rd_data == pat(addr), "R10 read data", rd_data, pat(addr));
      chk(!mem_ce_n && mem_oe_n && mem_adv_n && mem_we_n, "R8 hold strobes",
          {mem_ce_n, mem_oe_n, mem_adv_n, mem_we_n}, 4'b0111);
      last_rd   = pat(addr);
      prev_read = 1;
      prev_page = addr[22:4];
    end else begin
      exp_gap = in_win ? 1 : 0;
      chk(cnt == WR, "R5 write length", cnt, WR);
      chk(gap == exp_gap, "R7 turnaround", gap, exp_gap);
      if (kind == 1)
        chk(s_addr == 32'(addr) && s_dq == 32'(wd) && s_oe_en && s_oe && !s_adv &&
            !s_cre && s_ub == ~be[1] && s_lb == ~be[0], "R5 write strobes",
            {s_dq[15:0], s_oe_en, s_ub, s_lb}, {wd, 1'b1, ~be});
      else
        chk(s_addr == 32'(addr | 23'h8000) && s_cre && !s_oe_en && s_oe && s_ub && s_lb,
            "R6 config write", s_addr, 32'(addr | 23'h8000));
      chk(rd_data == last_rd, "R10 read data kept", rd_data, last_rd);
      chk(mem_ce_n && !mem_dq_oe, "R11 bus released", {mem_ce_n, mem_dq_oe}, 2'b10);
      prev_read = 0;
    end
    if (spurious) begin
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        chk(mem_we_n && !ack, "R9 busy request ignored", {mem_we_n, ack}, 2'b10);
      end
      prev_read = 0;
    end
  endtask

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && mem_adv_n && !mem_cre && !mem_dq_oe && !ack,
        "R1 in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_cre, mem_dq_oe}, 5'b11100);
    rst = 0;
    @(negedge clk);
    chk(mem_ce_n && mem_ub_n && mem_lb_n && !busy && !ack, "R1 after reset",
        {mem_ce_n, mem_ub_n, mem_lb_n, busy, ack}, 5'b11100);

    // directed corners
    do_op(0, 23'h012345, 0, 0, 0, 0);             // R2 random from standby
    do_op(0, 23'h01234A, 0, 0, 0, 0);             // R3 same page
    do_op(0, 23'h012355, 0, 0, HOLD - 1, 0);      // R4 other page, last window cycle
    do_op(0, 23'h012351, 0, 0, HOLD - 1, 0);      // R3 hit on last window cycle
    do_op(0, 23'h012352, 0, 0, HOLD, 0);          // R4 window expired
    // R8 window length
    for (int i = 0; i < HOLD; i++) begin
      if (i > 0) @(negedge clk);
      chk(!mem_ce_n, "R8 ce held", mem_ce_n, 0);
    end
    @(negedge clk);
    chk(mem_ce_n, "R8 ce released", mem_ce_n, 1);
    prev_read = 0;
    do_op(1, 23'h000100, 16'hBEEF, 2'b01, 0, 0);  // R5 from standby
    do_op(0, 23'h000100, 0, 0, 0, 0);
    do_op(1, 23'h000101, 16'h1234, 2'b10, 0, 0);  // R7 turnaround
    do_op(0, 23'h000200, 0, 0, 1, 0);
    do_op(2, 23'h001234, 0, 0, 0, 0);             // R6 bit 15 forced
    do_op(0, 23'h7FFFFF, 0, 0, 2, 1);             // R9 spurious during read
    do_op(1, 23'h400000, 16'h00FF, 2'b11, 0, 1);  // R9 spurious during write

    // constrained random
    for (int n = 0; n < 80; n++) begin
      int r = int'($urandom % 4);
      int k = (r < 2) ? 0 : r - 1;
      logic [22:0] a = 23'($urandom);
      if (($urandom % 2) == 1) a = {prev_page, a[3:0]};
      if (k == 2) a[15] = 1'b0;
      do_op(k, a, 16'($urandom), 2'($urandom), int'($urandom % 6), 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule